// File: doc/BRIEF.md
# Framing-Error Loss-of-Frame Monitor

This block watches a stream of per-frame framing-bit check results while the frame alignment is already held, and decides when that alignment has been lost. Each result arrives as an error flag qualified by a valid strobe. The block keeps a short history of recent results. In T1 mode it applies a sliding M-of-N error test whose window is chosen by a three-bit criterion selector. In E1 mode it uses a fixed rule of three consecutive errors.

When the active test is met, a sticky loss-of-frame status rises. In the same cycle, a single-cycle resynchronisation request is sent to the offline search framer. The block never searches for alignment itself. When the offline framer reports a newly found alignment with a one-cycle pulse, the status clears and the history is emptied.

Top module: `lof_monitor`

## Requirements
- R1: After reset, `lof` and `resync_req` are 0 and the error history is empty.
- R2: In T1 mode (`e1_mode`=0) with `crit_sel`=3'b000, `lof` is declared when the newest 4 valid results hold at least 2 errors.
- R3: In T1 mode with `crit_sel`=3'b001, `lof` is declared when the newest 5 valid results hold at least 2 errors.
- R4: In T1 mode with `crit_sel`=3'b010, `lof` is declared when the newest 6 valid results hold at least 2 errors.
- R5: In T1 mode, every `crit_sel` value from 3'b011 to 3'b111 applies the same rule as 3'b000 (2 errors in 4).
- R6: In E1 mode (`e1_mode`=1), `lof` is declared only when the newest 3 valid results are all errors. `crit_sel` has no effect in this mode.
- R7: A strobe (`frm_valid`=1) is sampled on a rising clock edge. If that strobe meets the criterion, `lof` reads 1 from the next cycle on. `resync_req` is 1 for exactly that first cycle and then returns to 0.
- R8: A `realign` pulse clears `lof` and empties the history on the next edge. A strobe presented in the same cycle as `realign` is discarded.
- R9: Once set, `lof` stays at 1 until `realign`, whatever results arrive. No further `resync_req` pulse is produced while it stays set.
- R10: Cycles with `frm_valid`=0 leave the history and `lof` unchanged, whatever value `frm_err` has.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_valid | input | 1 | Strobe: one framing-bit result this cycle |
| frm_err | input | 1 | The result is a framing error (used only with frm_valid) |
| e1_mode | input | 1 | 1 = E1 consecutive rule, 0 = T1 window rule |
| crit_sel | input | 3 | T1 window select: 000 = 2/4, 001 = 2/5, 010 = 2/6, other values = 2/4 |
| realign | input | 1 | One-cycle pulse: the offline framer found a new alignment |
| lof | output | 1 | Loss-of-frame status (sticky) |
| resync_req | output | 1 | One-cycle request to the offline framer |

## Verification
The hardest case to reach is an error pair that sits exactly on the edge of a window. The two errors must be just far enough apart to fall inside one window length and just outside the next shorter one. The case also needs an empty starting history, so that older results cannot take part in the count. Each scenario therefore begins with a `realign` pulse. It then sends a pair of errors separated by N-2 clean results, and a second pair separated by N-1. It also places a `realign` pulse on the same cycle as an erroring strobe, then sends one more error; a history that kept the old error, or a strobe that was not discarded, would show up as a false declaration.

// File: rtl/lof_monitor.sv
module lof_monitor #(
  parameter int HIST_W   = 6,
  parameter int T1_THR   = 2,
  parameter int E1_RUN   = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frm_valid,
  input  logic       frm_err,
  input  logic       e1_mode,
  input  logic [2:0] crit_sel,
  input  logic       realign,
  output logic       lof,
  output logic       resync_req
);
  localparam int CNT_W = $clog2(HIST_W + 1);

  logic [HIST_W-1:0] hist;
  logic [HIST_W-1:0] hist_nx;
  logic [CNT_W-1:0]  win_len;
  logic [CNT_W-1:0]  err_cnt;
  logic              t1_hit, e1_hit, hit;

  assign hist_nx = {hist[HIST_W-2:0], frm_err};

  always_comb begin
    case (crit_sel)
      3'b001:  win_len = CNT_W'(5);
      3'b010:  win_len = CNT_W'(6);
      default: win_len = CNT_W'(4);
    endcase
  end

  always_comb begin
    err_cnt = '0;
    for (int i = 0; i < HIST_W; i++)
      if (hist_nx[i] && (CNT_W'(i) < win_len))
        err_cnt = err_cnt + CNT_W'(1);
  end

  assign t1_hit = err_cnt >= CNT_W'(T1_THR);
  assign e1_hit = &hist_nx[E1_RUN-1:0];
  assign hit    = e1_mode ? e1_hit : t1_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist       <= '0;
      lof        <= 1'b0;
      resync_req <= 1'b0;
    end else if (realign) begin
      hist       <= '0;
      lof        <= 1'b0;
      resync_req <= 1'b0;
    end else begin
      resync_req <= 1'b0;
      if (frm_valid) begin
        hist <= hist_nx;
        if (hit && !lof) begin
          lof        <= 1'b1;
          resync_req <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/lof_monitor_chk.sv
module lof_monitor_chk (
  input logic clk,
  input logic rst_n,
  input logic frm_valid,
  input logic frm_err,
  input logic realign,
  input logic lof,
  input logic resync_req
);
  // R7
  resync_with_lof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resync_req |-> lof);
  // R7
  resync_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resync_req |=> !resync_req);
  // R7
  rise_pulses_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lof) |-> resync_req);
  // R7
  rise_needs_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lof) |-> $past(frm_valid && frm_err && !realign));
  // R8
  realign_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    realign |=> !lof);
  // R9
  lof_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lof && !realign) |=> lof);
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!frm_valid && !realign) |=> $stable(lof));
endmodule

bind lof_monitor lof_monitor_chk chk_i (
  .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_err(frm_err),
  .realign(realign), .lof(lof), .resync_req(resync_req)
);

// File: tb/lof_monitor_tb_top.sv
module lof_monitor_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frm_valid = 1'b0, frm_err = 1'b0, e1_mode = 1'b0, realign = 1'b0;
  logic [2:0] crit_sel = 3'b000;
  logic lof, resync_req;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  lof_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_err(frm_err),
    .e1_mode(e1_mode), .crit_sel(crit_sel), .realign(realign),
    .lof(lof), .resync_req(resync_req)
  );

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic send(logic e);
    @(negedge clk); frm_valid = 1'b1; frm_err = e;
    @(negedge clk); frm_valid = 1'b0; frm_err = 1'b0;
  endtask

  task automatic send_seq(logic [15:0] bits, int n);
    for (int i = n - 1; i >= 0; i--) send(bits[i]);
  endtask

  task automatic do_realign();
    @(negedge clk); realign = 1'b1;
    @(negedge clk); realign = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 lof", lof, 1'b0);
    chk("R1 resync", resync_req, 1'b0);
  endtask

  task automatic t_window(string req, logic [2:0] sel, int n);
    e1_mode = 1'b0; crit_sel = sel;
    do_realign();
    send(1'b1);
    for (int i = 0; i < n - 1; i++) send(1'b0);
    send(1'b1);
    chk({req, " outside window"}, lof, 1'b0);
    do_realign();
    send(1'b1);
    for (int i = 0; i < n - 2; i++) send(1'b0);
    chk({req, " before 2nd err"}, lof, 1'b0);
    send(1'b1);
    chk({req, " inside window lof"}, lof, 1'b1);
    chk({req, " R7 resync pulse"}, resync_req, 1'b1);
    @(negedge clk);
    chk({req, " R7 resync drops"}, resync_req, 1'b0);
    chk({req, " lof held"}, lof, 1'b1);
  endtask

  task automatic t_e1();
    e1_mode = 1'b1; crit_sel = 3'b000;
    do_realign();
    send_seq(16'b110110, 6);
    chk("R6 non-consecutive", lof, 1'b0);
    send_seq(16'b11, 2);
    chk("R6 two in a row", lof, 1'b0);
    send(1'b1);
    chk("R6 three in a row", lof, 1'b1);
    chk("R6 R7 resync", resync_req, 1'b1);
    crit_sel = 3'b010;
    do_realign();
    send_seq(16'b10101, 5);
    chk("R6 crit_sel ignored", lof, 1'b0);
    e1_mode = 1'b0; crit_sel = 3'b000;
  endtask

  task automatic t_sticky();
    e1_mode = 1'b0; crit_sel = 3'b000;
    do_realign();
    send_seq(16'b11, 2);
    chk("R9 set", lof, 1'b1);
    send_seq(16'b0000000, 7);
    chk("R9 sticky lof", lof, 1'b1);
    chk("R9 no resync", resync_req, 1'b0);
    send_seq(16'b11, 2);
    chk("R9 no repeat resync", resync_req, 1'b0);
    do_realign();
    chk("R8 cleared", lof, 1'b0);
  endtask

  task automatic t_realign_flush();
    e1_mode = 1'b0; crit_sel = 3'b000;
    do_realign();
    send(1'b1);
    @(negedge clk); realign = 1'b1; frm_valid = 1'b1; frm_err = 1'b1;
    @(negedge clk); realign = 1'b0; frm_valid = 1'b0; frm_err = 1'b0;
    chk("R8 realign+strobe", lof, 1'b0);
    send(1'b1);
    chk("R8 history flushed", lof, 1'b0);
    send(1'b1);
    chk("R8 fresh pair", lof, 1'b1);
  endtask

  task automatic t_idle();
    e1_mode = 1'b0; crit_sel = 3'b000;
    do_realign();
    send(1'b1);
    @(negedge clk); frm_err = 1'b1;
    repeat (10) @(negedge clk);
    frm_err = 1'b0;
    chk("R10 idle err ignored", lof, 1'b0);
    send_seq(16'b0001, 4);
    chk("R10 idle no shift", lof, 1'b0);
  endtask

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_window("R2", 3'b000, 4);
    t_window("R3", 3'b001, 5);
    t_window("R4", 3'b010, 6);
    t_window("R5 sel011", 3'b011, 4);
    t_window("R5 sel101", 3'b101, 4);
    t_window("R5 sel111", 3'b111, 4);
    t_e1();
    t_sticky();
    t_realign_flush();
    t_idle();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule